// File: doc/BRIEF.md
# Dual-Clock FIFO with Mark and Rewind

This block is a two-clock first-in first-out buffer for 36-bit words. The writer and reader each run on their own clock. The pointers pass between the two clock domains as gray code through two-stage synchronizers. Four active-low flags tell each side how much room or data is left. The "almost" flags trip at thresholds that software programs.

A write can be masked. The slot is then skipped: the write pointer moves on, but nothing is stored, so the old contents of that slot stay. The reader can mark its current position and later rewind to it, which replays the words read since the mark. When the select input `fifo_sel` is held low, both data ports switch to a small byte-wide register window that holds the two threshold values.

A master reset empties the buffer and restores the default thresholds. A partial reset empties the buffer but keeps the thresholds that were programmed.

Top module: `mark_fifo`

## Requirements
- R1: With `fifo_sel` high and the buffer not full, a `wr_en` cycle always advances the write position. It stores `din` in that slot only when `in_en` is high; otherwise the slot keeps its previous contents.
- R2: Words are read out in the order they were written. A write attempted while `full_n` is low is ignored: nothing is stored and the write position does not move.
- R3: A read attempted while `empty_n` is low is ignored. In any cycle without an accepted read, `dout` holds its value.
- R4: With `fifo_sel` low, a `wr_en` cycle stores `din[7:0]` into the configuration byte chosen by an internal index, and a `rd_en` cycle puts that byte on `dout` with all upper bits zero. Each access moves the index on, in the order 0 to 3 and then back to 0. The bytes are:
  - index 0: empty threshold, low byte
  - index 1: empty threshold, high byte
  - index 2: full threshold, low byte
  - index 3: full threshold, high byte
- R5: The configuration index of each side returns to 0 whenever `fifo_sel` is high.
- R6: A `mark` cycle in the read domain records the current read position.
- R7: A `rewind` cycle loads the read position with the recorded mark. Later reads return the words again, in their original order, until the read position catches up with the write position.
- R8: `empty_n` is low when no words are held, as seen in the read domain. `full_n` is low when 2^ADDR_W words are held, as seen in the write domain. Each flag reflects a change made by the other side within four of its own clock cycles.
- R9: `aempty_n` is low when the number of words held is less than or equal to the 16-bit empty threshold (high byte : low byte).
- R10: `afull_n` is low when the number of free slots is less than or equal to the 16-bit full threshold.
- R11: A master reset (`mrst_n` low) does the following:
  - clears both positions and `dout`;
  - sets both thresholds to 7;
  - leaves the flags at empty_n=0, aempty_n=0, full_n=1, afull_n=1.
- R12: A partial reset (`prst_n` low) clears the positions, `dout` and the flags in the same way as a master reset, but keeps the programmed thresholds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, asynchronous, active low |
| fifo_sel | input | 1 | High: data ports access the buffer; low: configuration window |
| wr_en | input | 1 | Write request |
| in_en | input | 1 | Store enable; when low, a write skips its slot |
| din | input | 36 | Write data |
| rd_en | input | 1 | Read request |
| mark | input | 1 | Record the current read position (read domain) |
| rewind | input | 1 | Return the read position to the mark (read domain) |
| dout | output | 36 | Registered read data |
| empty_n | output | 1 | Low when empty (read domain) |
| aempty_n | output | 1 | Low at or below the empty threshold (read domain) |
| full_n | output | 1 | Low when full (write domain) |
| afull_n | output | 1 | Low at or below the full threshold of free space (write domain) |

## Verification
The bench checks both almost-flags one word either side of their thresholds, first with the default values and then with programmed ones. An off-by-one in a comparison therefore moves a flag edge by one word and is caught.

A masked write is followed by a read of the skipped slot. That read must return the stale word left there by an earlier pass. A design that does not advance on a masked write would return the next stored word in its place and would run empty one read too early.

The configuration test writes one byte, drops the select, and then rewrites all four bytes. A design whose index does not return to zero would leave the bytes rotated. The rewind test replays three words and then expects empty. A design that restores the wrong position would return shifted data or too many words.

// File: rtl/mfifo_pkg.sv
`timescale 1ns/1ps
package mfifo_pkg;
  localparam int unsigned CFG_REGS = 4;
  localparam int unsigned IDX_W    = $clog2(CFG_REGS);
  localparam int unsigned OFF_W    = 16;
  localparam logic [7:0]  THR_DEF  = 8'd7;

  typedef enum logic [IDX_W-1:0] {
    CFG_AE_LO = 2'd0,
    CFG_AE_HI = 2'd1,
    CFG_AF_LO = 2'd2,
    CFG_AF_HI = 2'd3
  } cfg_idx_e;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/mfifo_rst_sync.sv
`timescale 1ns/1ps
module mfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      rst_n  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_n  <= meta_q;
    end
  end
endmodule

// File: rtl/mfifo_gray_sync.sv
`timescale 1ns/1ps
module mfifo_gray_sync #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      q       <= '0;
    end else begin
      stage_q <= d;
      q       <= stage_q;
    end
  end
endmodule

// File: rtl/mfifo_ram.sv
`timescale 1ns/1ps
module mfifo_ram #(
  parameter int unsigned DW = 36,
  parameter int unsigned AW = 4
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mfifo_wr_ctl.sv
`timescale 1ns/1ps
module mfifo_wr_ctl
  import mfifo_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_rst_n,
  input  logic                            fifo_sel,
  input  logic                            wr_en,
  input  logic                            in_en,
  input  logic [7:0]                      cfg_byte,
  input  logic [AW:0]                     rd_gray_s,
  output logic [AW:0]                     wr_gray,
  output logic                            mem_we,
  output logic [AW-1:0]                   mem_waddr,
  output logic [CFG_REGS-1:0][7:0]        cfg_q,
  output logic                            full_n,
  output logic                            afull_n
);
  localparam int unsigned PTR_W   = AW + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << AW);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, wr_gray_d;
  logic [PTR_W-1:0] rd_bin, used, free;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CFG_REGS-1:0][7:0] cfg_d;
  logic [OFF_W-1:0] af_off;
  logic is_full, fifo_wr, cfg_wr;

  // next state
  always_comb begin
    rd_bin  = PTR_W'(gray_to_bin(32'(rd_gray_s)));
    used    = wr_ptr_q - rd_bin;
    free    = DEPTH_P - used;
    is_full = (used == DEPTH_P);
    fifo_wr = wr_en & fifo_sel & ~is_full;
    cfg_wr  = wr_en & ~fifo_sel;
    wr_ptr_d  = wr_ptr_q + PTR_W'(1);
    wr_gray_d = PTR_W'(bin_to_gray(32'(wr_ptr_d)));
    idx_d = idx_q;
    if (fifo_sel)    idx_d = '0;
    else if (cfg_wr) idx_d = idx_q + IDX_W'(1);
    cfg_d = cfg_q;
    if (cfg_wr) cfg_d[idx_q] = cfg_byte;
    af_off = {cfg_q[CFG_AF_HI], cfg_q[CFG_AF_LO]};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      wr_gray  <= '0;
    end else if (fifo_wr) begin
      wr_ptr_q <= wr_ptr_d;
      wr_gray  <= wr_gray_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n) begin
      cfg_q <= '0;
      cfg_q[CFG_AE_LO] <= THR_DEF;
      cfg_q[CFG_AF_LO] <= THR_DEF;
    end else if (cfg_wr) begin
      cfg_q <= cfg_d;
    end
  end

  assign mem_we    = fifo_wr & in_en;
  assign mem_waddr = wr_ptr_q[AW-1:0];
  assign full_n    = ~is_full;
  assign afull_n   = ~(OFF_W'(free) <= af_off);

  // R1: a masked write still consumes its slot
  a_r1_mask_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_sel && full_n && !in_en) |=> (wr_ptr_q == $past(wr_ptr_q) + PTR_W'(1)));

  // R2: a write while full leaves the write position unchanged
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_sel && !full_n) |=> $stable(wr_ptr_q));
endmodule

// File: rtl/mfifo_rd_ctl.sv
`timescale 1ns/1ps
module mfifo_rd_ctl
  import mfifo_pkg::*;
#(
  parameter int unsigned DW = 36,
  parameter int unsigned AW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fifo_sel,
  input  logic                     rd_en,
  input  logic                     mark,
  input  logic                     rewind,
  input  logic [AW:0]              wr_gray_s,
  input  logic [DW-1:0]            rdata,
  input  logic [CFG_REGS-1:0][7:0] cfg_q,
  output logic [AW:0]              rd_gray,
  output logic [AW-1:0]            mem_raddr,
  output logic [DW-1:0]            dout,
  output logic                     empty_n,
  output logic                     aempty_n
);
  localparam int unsigned PTR_W = AW + 1;

  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d, rd_gray_d, mark_q, mark_d;
  logic [PTR_W-1:0] wr_bin, level;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [DW-1:0]    dout_d;
  logic [OFF_W-1:0] ae_off;
  logic is_empty, fifo_rd, cfg_rd, ptr_en;

  // next state
  always_comb begin
    wr_bin   = PTR_W'(gray_to_bin(32'(wr_gray_s)));
    level    = wr_bin - rd_ptr_q;
    is_empty = (level == '0);
    fifo_rd  = rd_en & fifo_sel & ~is_empty & ~rewind;
    cfg_rd   = rd_en & ~fifo_sel;
    ptr_en   = fifo_rd | rewind;
    rd_ptr_d = rewind ? mark_q : rd_ptr_q + PTR_W'(1);
    rd_gray_d = PTR_W'(bin_to_gray(32'(rd_ptr_d)));
    mark_d   = mark ? rd_ptr_q : mark_q;
    idx_d = idx_q;
    if (fifo_sel)    idx_d = '0;
    else if (cfg_rd) idx_d = idx_q + IDX_W'(1);
    dout_d = dout;
    if (fifo_rd)     dout_d = rdata;
    else if (cfg_rd) dout_d = DW'(cfg_q[idx_q]);
    ae_off = {cfg_q[CFG_AE_HI], cfg_q[CFG_AE_LO]};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      rd_gray  <= '0;
    end else if (ptr_en) begin
      rd_ptr_q <= rd_ptr_d;
      rd_gray  <= rd_gray_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q <= '0;
      idx_q  <= '0;
      dout   <= '0;
    end else begin
      mark_q <= mark_d;
      idx_q  <= idx_d;
      dout   <= dout_d;
    end
  end

  assign mem_raddr = rd_ptr_q[AW-1:0];
  assign empty_n   = ~is_empty;
  assign aempty_n  = ~(OFF_W'(level) <= ae_off);

  // R3: a read while empty leaves the read position unchanged
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fifo_sel && !empty_n && !rewind) |=> $stable(rd_ptr_q));

  // R3: output register holds without a read request
  a_r3_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |=> $stable(dout));

  // R7: rewind restores the recorded position
  a_r7_rewind_load: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (rd_ptr_q == $past(mark_q)));
endmodule

// File: rtl/mark_fifo.sv
`timescale 1ns/1ps
module mark_fifo
  import mfifo_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              fifo_sel,
  input  logic              wr_en,
  input  logic              in_en,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_en,
  input  logic              mark,
  input  logic              rewind,
  output logic [DATA_W-1:0] dout,
  output logic              empty_n,
  output logic              aempty_n,
  output logic              full_n,
  output logic              afull_n
);
  localparam int unsigned PTR_W = ADDR_W + 1;

  logic any_rst_n, wr_rst_n, cfg_rst_n, rd_rst_n;
  logic [PTR_W-1:0] wr_gray, wr_gray_s, rd_gray, rd_gray_s;
  logic mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_rdata;
  logic [CFG_REGS-1:0][7:0] cfg_q;

  assign any_rst_n = mrst_n & prst_n;

  mfifo_rst_sync u_wr_rst  (.clk(wr_clk), .arst_n(any_rst_n), .rst_n(wr_rst_n));
  mfifo_rst_sync u_cfg_rst (.clk(wr_clk), .arst_n(mrst_n),    .rst_n(cfg_rst_n));
  mfifo_rst_sync u_rd_rst  (.clk(rd_clk), .arst_n(any_rst_n), .rst_n(rd_rst_n));

  mfifo_gray_sync #(.W(PTR_W)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_s));
  mfifo_gray_sync #(.W(PTR_W)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_s));

  mfifo_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wr_clk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(din),
    .raddr(mem_raddr), .rdata(mem_rdata));

  mfifo_wr_ctl #(.AW(ADDR_W)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .cfg_rst_n(cfg_rst_n),
    .fifo_sel(fifo_sel), .wr_en(wr_en), .in_en(in_en), .cfg_byte(din[7:0]),
    .rd_gray_s(rd_gray_s), .wr_gray(wr_gray), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .cfg_q(cfg_q), .full_n(full_n), .afull_n(afull_n));

  mfifo_rd_ctl #(.DW(DATA_W), .AW(ADDR_W)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .fifo_sel(fifo_sel), .rd_en(rd_en),
    .mark(mark), .rewind(rewind), .wr_gray_s(wr_gray_s), .rdata(mem_rdata),
    .cfg_q(cfg_q), .rd_gray(rd_gray), .mem_raddr(mem_raddr), .dout(dout),
    .empty_n(empty_n), .aempty_n(aempty_n));
endmodule

// File: tb/mark_fifo_tb.sv
`timescale 1ns/1ps
module mark_fifo_tb;
  logic        clk;
  logic        mrst_n, prst_n, fifo_sel, wr_en, in_en, rd_en, mark, rewind;
  logic [35:0] din, dout;
  logic        empty_n, aempty_n, full_n, afull_n;
  int          checks, errors;
  bit          done;

  mark_fifo u_dut (
    .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fifo_sel(fifo_sel), .wr_en(wr_en), .in_en(in_en), .din(din),
    .rd_en(rd_en), .mark(mark), .rewind(rewind), .dout(dout),
    .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [35:0] d, input logic en);
    @(negedge clk); wr_en = 1'b1; in_en = en; din = d;
    @(negedge clk); wr_en = 1'b0; in_en = 1'b1;
  endtask

  task automatic rd(output logic [35:0] d);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = dout;
  endtask

  task automatic pulse_mark();
    @(negedge clk); mark = 1'b1;
    @(negedge clk); mark = 1'b0;
  endtask

  task automatic pulse_rewind();
    @(negedge clk); rewind = 1'b1;
    @(negedge clk); rewind = 1'b0;
  endtask

  task automatic check_flags_reset(input string req);
    chk({req, " dout"}, dout, 36'h0);
    chk({req, " empty_n"}, {35'h0, empty_n}, 36'h0);
    chk({req, " aempty_n"}, {35'h0, aempty_n}, 36'h0);
    chk({req, " full_n"}, {35'h0, full_n}, 36'h1);
    chk({req, " afull_n"}, {35'h0, afull_n}, 36'h1);
  endtask

  task automatic cfg_expect(input string req, input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3);
    logic [35:0] v;
    @(negedge clk); fifo_sel = 1'b0;
    rd(v); chk({req, " cfg0"}, v, {28'h0, b0});
    rd(v); chk({req, " cfg1"}, v, {28'h0, b1});
    rd(v); chk({req, " cfg2"}, v, {28'h0, b2});
    rd(v); chk({req, " cfg3"}, v, {28'h0, b3});
    @(negedge clk); fifo_sel = 1'b1;
  endtask

  // R11: state after master reset
  task automatic t_reset();
    @(negedge clk); mrst_n = 1'b0;
    idle(2); mrst_n = 1'b1; idle(4);
    check_flags_reset("R11 reset");
  endtask

  // R2 R8 R9 R10 R3: default thresholds, full, ordering, ignored accesses
  task automatic t_fill();
    logic [35:0] v;
    for (int i = 0; i < 7; i++) wr(36'h100 + 36'(i), 1'b1);
    idle(4); chk("R9 level7 aempty_n", {35'h0, aempty_n}, 36'h0);
    wr(36'h107, 1'b1);
    idle(4); chk("R9 level8 aempty_n", {35'h0, aempty_n}, 36'h1);
    chk("R10 free8 afull_n", {35'h0, afull_n}, 36'h1);
    chk("R8 not empty", {35'h0, empty_n}, 36'h1);
    wr(36'h108, 1'b1);
    idle(4); chk("R10 free7 afull_n", {35'h0, afull_n}, 36'h0);
    for (int i = 9; i < 16; i++) wr(36'h100 + 36'(i), 1'b1);
    idle(4); chk("R8 full_n", {35'h0, full_n}, 36'h0);
    wr(36'hDEAD, 1'b1);
    for (int i = 0; i < 16; i++) begin
      rd(v); chk("R2 order", v, 36'h100 + 36'(i));
    end
    idle(4);
    chk("R2 extra write dropped empty_n", {35'h0, empty_n}, 36'h0);
    chk("R8 full_n released", {35'h0, full_n}, 36'h1);
    rd(v); chk("R3 read when empty", v, 36'h10F);
    idle(3); chk("R3 dout hold", dout, 36'h10F);
  endtask

  // R1: masked write skips a slot and keeps its old word
  task automatic t_mask();
    logic [35:0] v;
    wr(36'hA1, 1'b1);
    wr(36'hB2, 1'b0);
    wr(36'hC3, 1'b1);
    idle(4);
    rd(v); chk("R1 first", v, 36'hA1);
    rd(v); chk("R1 masked slot keeps old", v, 36'h101);
    rd(v); chk("R1 third", v, 36'hC3);
    idle(4); chk("R1 empty after three", {35'h0, empty_n}, 36'h0);
  endtask

  // R4 R5: configuration window, index restart and wrap
  task automatic t_config();
    logic [35:0] v;
    @(negedge clk); fifo_sel = 1'b0;
    wr({28'hFFFFFFF, 8'd5}, 1'b1);
    @(negedge clk); fifo_sel = 1'b1;
    @(negedge clk); fifo_sel = 1'b0;
    wr({28'hFFFFFFF, 8'd2}, 1'b1);
    wr({28'hFFFFFFF, 8'd0}, 1'b1);
    wr({28'hFFFFFFF, 8'd3}, 1'b1);
    wr({28'hFFFFFFF, 8'd0}, 1'b1);
    rd(v); chk("R5 cfg0 after restart", v, 36'd2);
    rd(v); chk("R4 cfg1", v, 36'd0);
    rd(v); chk("R4 cfg2", v, 36'd3);
    rd(v); chk("R4 cfg3", v, 36'd0);
    rd(v); chk("R4 index wrap", v, 36'd2);
    @(negedge clk); fifo_sel = 1'b1;
  endtask

  // R9 R10: programmed thresholds (empty 2, full 3)
  task automatic t_prog_thr();
    wr(36'h1, 1'b1); wr(36'h2, 1'b1);
    idle(4); chk("R9 level2 aempty_n", {35'h0, aempty_n}, 36'h0);
    wr(36'h3, 1'b1);
    idle(4); chk("R9 level3 aempty_n", {35'h0, aempty_n}, 36'h1);
    for (int i = 0; i < 9; i++) wr(36'h10 + 36'(i), 1'b1);
    idle(4); chk("R10 free4 afull_n", {35'h0, afull_n}, 36'h1);
    wr(36'h20, 1'b1);
    idle(4); chk("R10 free3 afull_n", {35'h0, afull_n}, 36'h0);
  endtask

  // R12: partial reset keeps thresholds
  task automatic t_partial();
    logic [35:0] v;
    @(negedge clk); prst_n = 1'b0;
    idle(2); prst_n = 1'b1; idle(4);
    check_flags_reset("R12 partial");
    cfg_expect("R12 kept", 8'd2, 8'd0, 8'd3, 8'd0);
    wr(36'h55, 1'b1); idle(4);
    rd(v); chk("R12 data after partial", v, 36'h55);
  endtask

  // R11: master reset restores defaults
  task automatic t_master();
    @(negedge clk); mrst_n = 1'b0;
    idle(2); mrst_n = 1'b1; idle(4);
    check_flags_reset("R11 master");
    cfg_expect("R11 defaults", 8'd7, 8'd0, 8'd7, 8'd0);
  endtask

  // R6 R7: mark, rewind and replay up to the write position
  task automatic t_rewind();
    logic [35:0] v;
    for (int i = 1; i <= 4; i++) wr(36'h200 + 36'(i), 1'b1);
    idle(4);
    rd(v); chk("R6 pre-mark read", v, 36'h201);
    pulse_mark();
    for (int i = 2; i <= 4; i++) begin
      rd(v); chk("R6 read after mark", v, 36'h200 + 36'(i));
    end
    idle(4); chk("R7 empty before rewind", {35'h0, empty_n}, 36'h0);
    pulse_rewind();
    idle(4); chk("R7 data after rewind", {35'h0, empty_n}, 36'h1);
    for (int i = 2; i <= 4; i++) begin
      rd(v); chk("R7 replay", v, 36'h200 + 36'(i));
    end
    idle(4); chk("R7 stops at write position", {35'h0, empty_n}, 36'h0);
    rd(v); chk("R7 no read past write position", v, 36'h204);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    mrst_n = 1'b0; prst_n = 1'b1; fifo_sel = 1'b1;
    wr_en = 1'b0; in_en = 1'b1; din = '0;
    rd_en = 1'b0; mark = 1'b0; rewind = 1'b0;
    idle(2);
    t_reset();
    t_fill();
    t_mask();
    t_config();
    t_prog_thr();
    t_partial();
    t_master();
    t_rewind();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule